// File: doc/BRIEF.md
# DMA Element Mover with Descriptor Chaining

This block does the data-moving work for one granted DMA channel. An arbiter outside it hands over the channel's live state: source address, destination address, link pointer and the 32-bit control word. The block then moves exactly one element: one read from the source and one write to the destination, both through a single memory port. It advances the enabled addresses, counts the element off the 12-bit transfer count and hands the updated state back. When the count reaches zero, the block does one of two things. If a link pointer is present, it fetches the next four-word descriptor. If not, it tells the channel owner to clear the channel's enable bit.

The grant arrives on a valid/ready handshake. `start_ready` is high only while the engine is idle, and a grant is taken on a cycle where both `start_valid` and `start_ready` are high. The memory request side is also valid/ready. Once raised, a request keeps its address, direction, size and write data unchanged until the memory accepts it. Only one request is outstanding at a time. The next request is issued only after `mem_rsp_valid` has returned for the previous one. Responses cannot be back-pressured.

Each grant ends with a one-cycle `done_valid`, which carries the updated channel state and the `tc_evt`, `err_evt` and `done_clr_en` flags.

Top module: `dma_elem_engine`

## Requirements
- R1: After reset, `start_ready` is 1 and `mem_req_valid` and `done_valid` are 0. `start_ready` stays 0 from the cycle after a grant is taken until the engine has returned to idle after `done_valid`.
- R2: An element is one read at the source address followed by one write at the destination address, both with `mem_req_size` equal to the width code. Read data is taken from the byte lanes selected by the low source address bits and placed on the lanes selected by the low destination address bits. Memory data is little-endian, with byte k on bits 8k+7:8k.
- R3: Element width is 2^code bytes. The source code is control bits 20:18 and the destination code is bits 23:21. If control bit 26 is set, the source address grows by the width after the element; if bit 27 is set, the destination address grows by the width. A clear bit leaves that address unchanged.
- R4: After each element, the returned control word carries the count (bits 11:0) minus one, with bits 31:12 unchanged.
- R5: When the count reaches zero with a non-zero link pointer, the engine makes four word reads (`mem_req_size` = 2) at link+0, link+4, link+12 and link+8, in that order. These load the source address, destination address, control word and new link pointer respectively.
- R6: When the count reaches zero with a zero link pointer, `done_clr_en` is 1 with `done_valid`. Otherwise it is 0.
- R7: `tc_evt` is 1 with `done_valid` exactly when this element brought the count to zero and control bit 31 of the finished control word was set.
- R8: If the source and destination codes differ, or either code exceeds the data-bus width (code 2 for a 32-bit bus), the engine raises `err_evt`, issues no memory request and returns the state unchanged.
- R9: A grant whose count is already zero issues no memory request, raises no event and returns the state unchanged.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request fields hold. No new request is raised until the response to the previous one has arrived.
- R11: Every grant produces exactly one `done_valid` pulse one cycle long, carrying the granted channel number on `done_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Channel grant offered |
| start_ready | output | 1 | Engine idle, grant can be taken |
| start_ch | input | CH_W | Granted channel number |
| start_src | input | ADDR_W | Channel source address |
| start_dst | input | ADDR_W | Channel destination address |
| start_lli | input | ADDR_W | Channel link pointer (0 = none) |
| start_ctrl | input | 32 | Channel control word |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_size | output | 3 | log2 of access bytes |
| mem_req_wdata | output | DATA_W | Lane-aligned write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | DATA_W | Read data, full bus word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_ch | output | CH_W | Channel number of completed grant |
| done_src | output | ADDR_W | Updated source address |
| done_dst | output | ADDR_W | Updated destination address |
| done_lli | output | ADDR_W | Updated link pointer |
| done_ctrl | output | 32 | Updated control word |
| done_clr_en | output | 1 | Clear the channel enable bit |
| tc_evt | output | 1 | Terminal-count event |
| err_evt | output | 1 | Width-error event |

## Verification
On every cycle, the in-line properties check the following:
- the memory request holds under back-pressure;
- a request never overlaps an outstanding response;
- grants are locked out while busy;
- `done_valid` lasts one cycle;
- an error completion carries no terminal-count or enable-clear flag;
- an enable clear only ever comes with a zero link pointer.

Some results can only be shown by the bench's scenarios against its memory model:
- the address arithmetic for each width and increment setting;
- the count write-back with the upper control bits kept;
- byte-lane realignment of the moved data;
- the exact order of the descriptor fetch;
- the absence of memory traffic on zero-count and bad-width grants.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int CTRL_W = 32;
  localparam int CNT_W  = 12;
  localparam int SZ_W   = 3;
  localparam int SW_LSB = 18;
  localparam int DW_LSB = 21;
  localparam int SI_BIT = 26;
  localparam int DI_BIT = 27;
  localparam int TC_BIT = 31;
  localparam logic [SZ_W-1:0] DESC_SIZE = 3'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT,
    S_LL_REQ, S_LL_WAIT, S_FIN
  } eng_state_t;
endpackage

// File: rtl/dma_eng_ctrl_dec.sv
module dma_eng_ctrl_dec
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  cnt,
  output logic [SZ_W-1:0]   size,
  output logic [ADDR_W-1:0] step,
  output logic              inc_src,
  output logic              inc_dst,
  output logic              tc_en,
  output logic              bad_width,
  output logic              cnt_zero
);
  localparam int MAX_CODE = $clog2(DATA_W / 8);

  logic [SZ_W-1:0] sw, dw;

  always_comb begin
    sw        = ctrl[SW_LSB +: SZ_W];
    dw        = ctrl[DW_LSB +: SZ_W];
    cnt       = ctrl[CNT_W-1:0];
    size      = sw;
    step      = ADDR_W'(1) << sw;
    inc_src   = ctrl[SI_BIT];
    inc_dst   = ctrl[DI_BIT];
    tc_en     = ctrl[TC_BIT];
    bad_width = (sw != dw) || (int'(sw) > MAX_CODE);
    cnt_zero  = (cnt == '0);
  end
endmodule

// File: rtl/dma_eng_ll_seq.sv
module dma_eng_ll_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  output logic [1:0]        idx,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + 2'd1;
  end

  // fetch order: source, destination, control, then link
  always_comb begin
    case (idx)
      2'd0:    offs = ADDR_W'(0);
      2'd1:    offs = ADDR_W'(4);
      2'd2:    offs = ADDR_W'(12);
      default: offs = ADDR_W'(8);
    endcase
    addr = base + offs;
    last = (idx == 2'd3);
  end

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !clr) |=> (idx == 2'd0));
endmodule

// File: rtl/dma_elem_engine.sv
module dma_elem_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic [ADDR_W-1:0] start_lli,
  input  logic [CTRL_W-1:0] start_ctrl,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SZ_W-1:0]   mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              done_valid,
  output logic [CH_W-1:0]   done_ch,
  output logic [ADDR_W-1:0] done_src,
  output logic [ADDR_W-1:0] done_dst,
  output logic [ADDR_W-1:0] done_lli,
  output logic [CTRL_W-1:0] done_ctrl,
  output logic              done_clr_en,
  output logic              tc_evt,
  output logic              err_evt
);
  localparam int LANE_W = $clog2(DATA_W / 8);

  eng_state_t        state;
  logic [CH_W-1:0]   r_ch;
  logic [ADDR_W-1:0] r_src, r_dst, r_lli;
  logic [CTRL_W-1:0] r_ctrl;
  logic [DATA_W-1:0] r_data;
  logic              r_tc, r_err, r_clr;

  logic [CNT_W-1:0]  d_cnt;
  logic [SZ_W-1:0]   d_size;
  logic [ADDR_W-1:0] d_step;
  logic              d_si, d_di, d_tc, d_bad, d_zero;
  logic [CNT_W-1:0]  cnt_next;

  logic [1:0]        ll_idx;
  logic [ADDR_W-1:0] ll_addr;
  logic              ll_last;
  logic              ll_clr, ll_adv;

  dma_eng_ctrl_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .ctrl(r_ctrl), .cnt(d_cnt), .size(d_size), .step(d_step),
    .inc_src(d_si), .inc_dst(d_di), .tc_en(d_tc),
    .bad_width(d_bad), .cnt_zero(d_zero)
  );

  assign ll_clr = (state == S_CHK);
  assign ll_adv = (state == S_LL_WAIT) && mem_rsp_valid;

  dma_eng_ll_seq #(.ADDR_W(ADDR_W)) ll_i (
    .clk(clk), .rst_n(rst_n), .clr(ll_clr), .adv(ll_adv),
    .base(r_lli), .idx(ll_idx), .addr(ll_addr), .last(ll_last)
  );

  assign cnt_next = d_cnt - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      r_ch   <= '0;
      r_src  <= '0;
      r_dst  <= '0;
      r_lli  <= '0;
      r_ctrl <= '0;
      r_data <= '0;
      r_tc   <= 1'b0;
      r_err  <= 1'b0;
      r_clr  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          r_ch   <= start_ch;
          r_src  <= start_src;
          r_dst  <= start_dst;
          r_lli  <= start_lli;
          r_ctrl <= start_ctrl;
          r_tc   <= 1'b0;
          r_err  <= 1'b0;
          r_clr  <= 1'b0;
          state  <= S_CHK;
        end
        S_CHK: begin
          if (d_zero) state <= S_FIN;
          else if (d_bad) begin
            r_err <= 1'b1;
            state <= S_FIN;
          end else state <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          r_data <= mem_rsp_rdata >> {r_src[LANE_W-1:0], 3'b000};
          state  <= S_WR_REQ;
        end
        S_WR_REQ: if (mem_req_ready) state <= S_WR_WAIT;
        S_WR_WAIT: if (mem_rsp_valid) begin
          if (d_si) r_src <= r_src + d_step;
          if (d_di) r_dst <= r_dst + d_step;
          r_ctrl <= {r_ctrl[CTRL_W-1:CNT_W], cnt_next};
          if (cnt_next == '0) begin
            r_tc <= d_tc;
            if (r_lli != '0) state <= S_LL_REQ;
            else begin
              r_clr <= 1'b1;
              state <= S_FIN;
            end
          end else state <= S_FIN;
        end
        S_LL_REQ: if (mem_req_ready) state <= S_LL_WAIT;
        S_LL_WAIT: if (mem_rsp_valid) begin
          case (ll_idx)
            2'd0:    r_src  <= mem_rsp_rdata[ADDR_W-1:0];
            2'd1:    r_dst  <= mem_rsp_rdata[ADDR_W-1:0];
            2'd2:    r_ctrl <= mem_rsp_rdata[CTRL_W-1:0];
            default: r_lli  <= mem_rsp_rdata[ADDR_W-1:0];
          endcase
          state <= ll_last ? S_FIN : S_LL_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    start_ready   = (state == S_IDLE);
    mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ) || (state == S_LL_REQ);
    mem_req_we    = (state == S_WR_REQ);
    mem_req_wdata = r_data << {r_dst[LANE_W-1:0], 3'b000};
    case (state)
      S_WR_REQ: begin mem_req_addr = r_dst;   mem_req_size = d_size;    end
      S_LL_REQ: begin mem_req_addr = ll_addr; mem_req_size = DESC_SIZE; end
      default:  begin mem_req_addr = r_src;   mem_req_size = d_size;    end
    endcase
    done_valid  = (state == S_FIN);
    done_ch     = r_ch;
    done_src    = r_src;
    done_dst    = r_dst;
    done_lli    = r_lli;
    done_ctrl   = r_ctrl;
    done_clr_en = done_valid && r_clr;
    tc_evt      = done_valid && r_tc;
    err_evt     = done_valid && r_err;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata) && $stable(mem_req_size)));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  assert_grant_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> (!tc_evt && !done_clr_en));

  assert_clr_nolink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr_en |-> (done_lli == '0));
endmodule

// File: tb/dma_elem_engine_tb_top.sv
`timescale 1ns/1ps
module dma_elem_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [2:0]  start_ch = '0;
  logic [31:0] start_src = '0, start_dst = '0, start_lli = '0, start_ctrl = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [2:0]  mem_req_size;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done_valid, done_clr_en, tc_evt, err_evt;
  logic [2:0]  done_ch;
  logic [31:0] done_src, done_dst, done_lli, done_ctrl;

  always #10 clk = ~clk;

  dma_elem_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_ch(start_ch),
    .start_src(start_src), .start_dst(start_dst), .start_lli(start_lli),
    .start_ctrl(start_ctrl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_ch(done_ch), .done_src(done_src),
    .done_dst(done_dst), .done_lli(done_lli), .done_ctrl(done_ctrl),
    .done_clr_en(done_clr_en), .tc_evt(tc_evt), .err_evt(err_evt)
  );

  // memory model: 256 words, ready toggles, response one cycle after accept
  logic [31:0] mem [0:255];
  logic        pend;
  logic        pend_we;
  logic [31:0] pend_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= {i[7:0] + 8'h30, i[7:0] + 8'h20, i[7:0] + 8'h10, i[7:0]};
      mem[8'hC0] <= 32'h0000_0140;
      mem[8'hC1] <= 32'h0000_0240;
      mem[8'hC2] <= 32'h0000_0310;
      mem[8'hC3] <= 32'h0C48_0007;
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      pend <= 1'b0;
      pend_we <= 1'b0;
      pend_addr <= '0;
    end else begin
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= pend;
      if (pend && !pend_we) mem_rsp_rdata <= mem[pend_addr[9:2]];
      pend <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1;
        pend_we <= mem_req_we;
        pend_addr <= mem_req_addr;
        if (mem_req_we)
          for (int b = 0; b < 4; b++)
            if (b >= int'(mem_req_addr[1:0]) && b < int'(mem_req_addr[1:0]) + (1 << mem_req_size))
              mem[mem_req_addr[9:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
      end
    end
  end

  // request log and hold monitor, sampled at negedge
  int          nreq = 0;
  logic [31:0] log_addr [0:63];
  logic        log_we [0:63];
  logic [2:0]  log_size [0:63];
  logic        hold_bad = 1'b0;
  logic        p_stall = 1'b0;
  logic [31:0] p_addr, p_wdata;
  logic        p_we;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stall && !(mem_req_valid && mem_req_addr == p_addr && mem_req_we == p_we
                       && mem_req_wdata == p_wdata))
        hold_bad <= 1'b1;
      p_stall <= mem_req_valid && !mem_req_ready;
      p_addr  <= mem_req_addr;
      p_wdata <= mem_req_wdata;
      p_we    <= mem_req_we;
      if (mem_req_valid && mem_req_ready) begin
        log_addr[nreq[5:0]] <= mem_req_addr;
        log_we[nreq[5:0]]   <= mem_req_we;
        log_size[nreq[5:0]] <= mem_req_size;
        nreq <= nreq + 1;
      end
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] src, dst, lli, ctrl;
    logic [31:0] esrc, edst, elli, ectrl;
    logic [2:0]  eflags;  // {tc, err, clr}
    logic [3:0]  nreq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h100, 32'h200, 32'h0,   32'h0C48_0003, 32'h104, 32'h204, 32'h0,   32'h0C48_0002, 3'b000, 4'd2},
    '{32'h105, 32'h212, 32'h0,   32'h8400_0001, 32'h106, 32'h212, 32'h0,   32'h8400_0000, 3'b101, 4'd2},
    '{32'h102, 32'h220, 32'h0,   32'h8824_0002, 32'h102, 32'h222, 32'h0,   32'h8824_0001, 3'b000, 4'd2},
    '{32'h110, 32'h230, 32'h0,   32'h0C28_0005, 32'h110, 32'h230, 32'h0,   32'h0C28_0005, 3'b010, 4'd0},
    '{32'h110, 32'h230, 32'h0,   32'h0C6C_0004, 32'h110, 32'h230, 32'h0,   32'h0C6C_0004, 3'b010, 4'd0},
    '{32'h110, 32'h230, 32'h0,   32'h8C48_0000, 32'h110, 32'h230, 32'h0,   32'h8C48_0000, 3'b000, 4'd0},
    '{32'h108, 32'h208, 32'h300, 32'h8C48_0001, 32'h140, 32'h240, 32'h310, 32'h0C48_0007, 3'b100, 4'd6}
  };

  int base_req;
  logic busy_bad;
  logic timed_out;

  task automatic run_grant(input int ch, input vec_t v);
    base_req = nreq;
    busy_bad = 1'b0;
    timed_out = 1'b0;
    @(negedge clk);
    start_valid = 1'b1;
    start_ch = ch[2:0];
    start_src = v.src; start_dst = v.dst; start_lli = v.lli; start_ctrl = v.ctrl;
    @(negedge clk);
    start_valid = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done_valid) break;
      if (start_ready) busy_bad = 1'b1;
      if (t == 199) timed_out = 1'b1;
      @(negedge clk);
    end
    check("watchdog R11", {31'd0, timed_out}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset start_ready R1", {31'd0, start_ready}, 32'd1);
    check("reset mem_req_valid R1", {31'd0, mem_req_valid}, 32'd0);
    check("reset done_valid R1", {31'd0, done_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      run_grant(i, VECS[i]);
      check("done_ch R11", {29'd0, done_ch}, i);
      check("src update R3", done_src, VECS[i].esrc);
      check("dst update R3", done_dst, VECS[i].edst);
      check("lli R5", done_lli, VECS[i].elli);
      check("ctrl count R4", done_ctrl, VECS[i].ectrl);
      check("tc_evt R7", {31'd0, tc_evt}, {31'd0, VECS[i].eflags[2]});
      check("err_evt R8", {31'd0, err_evt}, {31'd0, VECS[i].eflags[1]});
      check("clr_en R6", {31'd0, done_clr_en}, {31'd0, VECS[i].eflags[0]});
      check("request count R9", nreq - base_req, {28'd0, VECS[i].nreq});
      check("busy lockout R1", {31'd0, busy_bad}, 32'd0);
      @(negedge clk);
      check("done one cycle R11", {31'd0, done_valid}, 32'd0);
      check("ready again R1", {31'd0, start_ready}, 32'd1);
      if (i == 0) begin
        check("read first R2", {31'd0, log_we[base_req[5:0]]}, 32'd0);
        check("read addr R2", log_addr[base_req[5:0]], 32'h100);
        check("write second R2", {31'd0, log_we[base_req[5:0]+6'd1]}, 32'd1);
        check("write addr R2", log_addr[base_req[5:0]+6'd1], 32'h200);
        check("word size R2", {29'd0, log_size[base_req[5:0]]}, 32'd2);
      end
      if (i == 6) begin
        check("ll addr0 R5", log_addr[base_req[5:0]+6'd2], 32'h300);
        check("ll addr1 R5", log_addr[base_req[5:0]+6'd3], 32'h304);
        check("ll addr2 R5", log_addr[base_req[5:0]+6'd4], 32'h30C);
        check("ll addr3 R5", log_addr[base_req[5:0]+6'd5], 32'h308);
        check("ll read R5", {31'd0, log_we[base_req[5:0]+6'd4]}, 32'd0);
        check("ll size R5", {29'd0, log_size[base_req[5:0]+6'd5]}, 32'd2);
      end
    end

    check("word data R2", mem[8'h80], 32'h7060_5040);
    check("byte lane data R2", mem[8'h84], 32'hB451_9484);
    check("half lane data R2", mem[8'h88], 32'hB8A8_7060);
    check("chained word data R2", mem[8'h82], 32'h7262_5242);
    check("untouched after error R8", mem[8'h8C], 32'hBCAC_9C8C);
    check("request hold R10", {31'd0, hold_bad}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule